// File: doc/BRIEF.md
# Disk Port Interrupt Status Register

This block keeps the interrupt state of one disk port. Two sticky flags live in it: a transfer-done flag and a bus-error flag. Hardware events raise them. Software raises them through a set word and drops them through a clear word; both words take a bit mask. While either flag is up, a registered, glitch-free interrupt line is high.

A bus error also latches the failing memory address into two readable words, low and high. While the error flag stays up, later errors do not overwrite that address.

A read of the drive status byte has a side effect. When the drive reports not busy, that read drops both flags, so the interrupt a host handler has just serviced goes away. When the drive is still busy, the read leaves the flags alone.

Top module: `pirq_regs`

## Requirements
- R1: After synchronous reset both flags are 0, `irq_o` is 0, `reg_rdata` is 0 and both captured address words read 0.
- R2: A one-cycle pulse on `xfer_evt` sets flag bit 0 and a pulse on `buserr_evt` sets flag bit 1. Each flag stays set until it is cleared.
- R3: A write to byte offset 0x14 (word 5) sets every flag whose bit in `reg_wmask[1:0]` is 1. Flags whose mask bit is 0 are unchanged.
- R4: A write to byte offset 0x1C (word 7) clears every flag whose bit in `reg_wmask[1:0]` is 1. Writing 0x3 clears both flags. Flags whose mask bit is 0 are unchanged.
- R5: When a hardware event or a software set arrives in the same cycle as a clear (register write or drive-status side effect) of the same flag, the flag ends up set.
- R6: A read of byte offset 0x0C (word 3) returns the flags in `reg_rdata[1:0]` (bit 0 transfer, bit 1 bus error, upper bits 0) in the cycle after the read strobe. `reg_rdata` is 0 in any cycle that follows no read, and for unmapped offsets.
- R7: A pulse on `drv_stat_rd` with `drv_busy` = 0 clears both flags.
- R8: A pulse on `drv_stat_rd` with `drv_busy` = 1 leaves both flags unchanged.
- R9: `irq_o` equals the OR of the two flags. It changes at the same clock edge as the flags.
- R10: On a bus-error event while flag bit 1 is clear, `err_addr_lo` and `err_addr_hi` are captured. They are readable at byte offsets 0x00 and 0x04. While flag bit 1 is set, a further error leaves the captured address unchanged.
- R11: Writes to the status offset 0x0C and to the address offsets 0x00 and 0x04 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wmask | input | 2 | Flag mask for set and clear writes |
| reg_rdata | output | DATA_W (32) | Registered read data |
| xfer_evt | input | 1 | Hardware transfer-done event |
| buserr_evt | input | 1 | Hardware bus-error event |
| err_addr_lo | input | DATA_W (32) | Low word of the failing address |
| err_addr_hi | input | DATA_W (32) | High word of the failing address |
| drv_stat_rd | input | 1 | Drive status byte is being read |
| drv_busy | input | 1 | Busy bit (bit 7) of the drive status byte |
| irq_o | output | 1 | Level interrupt |

## Verification
Every flag update takes effect at the clock edge that samples its cause. The interrupt line, the flags and the captured address are all due one edge after the stimulus. Read data is also due one edge after the strobe and shows the flags as they stood before that edge.

The bench drives every input on a falling edge. It samples on the next falling edge, after exactly one rising edge. Every check therefore lands in the cycle its result is due, and no check depends on process ordering at the rising edge.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int unsigned PEND_W     = 2;
    localparam int unsigned IDX_ERR_LO = 0;
    localparam int unsigned IDX_ERR_HI = 1;
    localparam int unsigned IDX_STAT   = 3;
    localparam int unsigned IDX_SET    = 5;
    localparam int unsigned IDX_CLR    = 7;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ERR_LO,
        ACC_ERR_HI,
        ACC_STAT,
        ACC_SET,
        ACC_CLR
    } acc_e;

    typedef struct packed {
        logic buserr;   // bit 1
        logic xfer;     // bit 0
    } pend_t;

    typedef struct packed {
        logic wr;
        logic rd;
        acc_e sel;
    } acc_t;

    function automatic logic [PEND_W-1:0] next_pend(
        input logic [PEND_W-1:0] cur,
        input logic [PEND_W-1:0] set_m,
        input logic [PEND_W-1:0] clr_m
    );
        // clear first, then set: set wins
        return (cur & ~clr_m) | set_m;
    endfunction

endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
    import pirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_t              acc
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        acc.wr  = wr;
        acc.rd  = rd;
        acc.sel = ACC_NONE;
        if (aligned) begin
            if (idx == IDX_W'(IDX_ERR_LO))      acc.sel = ACC_ERR_LO;
            else if (idx == IDX_W'(IDX_ERR_HI)) acc.sel = ACC_ERR_HI;
            else if (idx == IDX_W'(IDX_STAT))   acc.sel = ACC_STAT;
            else if (idx == IDX_W'(IDX_SET))    acc.sel = ACC_SET;
            else if (idx == IDX_W'(IDX_CLR))    acc.sel = ACC_CLR;
            else                                acc.sel = ACC_NONE;
        end
    end
endmodule

// File: rtl/pirq_sticky.sv
module pirq_sticky
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pend_t             hw_set,
    input  logic [PEND_W-1:0] sw_set,
    input  logic [PEND_W-1:0] sw_clr,
    input  logic              auto_clr,
    output pend_t             pend_q,
    output logic              irq_q
);
    logic [PEND_W-1:0] set_all;
    logic [PEND_W-1:0] clr_all;
    logic [PEND_W-1:0] pend_d;

    always_comb begin
        set_all = sw_set | PEND_W'(hw_set);
        clr_all = sw_clr | {PEND_W{auto_clr}};
        pend_d  = next_pend(PEND_W'(pend_q), set_all, clr_all);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_t'(pend_d);
            irq_q  <= |pend_d;
        end
    end

    AST_HW_SETS_XFER: assert property (@(posedge clk) disable iff (rst)
        hw_set.xfer |=> pend_q.xfer); // R5
    AST_HW_SETS_BUSERR: assert property (@(posedge clk) disable iff (rst)
        hw_set.buserr |=> pend_q.buserr); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (sw_clr[1] && !sw_set[1] && !hw_set.buserr) |=> !pend_q.buserr); // R4
    AST_AUTO_CLR: assert property (@(posedge clk) disable iff (rst)
        (auto_clr && sw_set == '0 && !hw_set.xfer && !hw_set.buserr) |=> (pend_q == '0)); // R7
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        irq_q == (pend_q.xfer || pend_q.buserr)); // R9
endmodule

// File: rtl/pirq_errcap.sv
module pirq_errcap #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_evt,
    input  logic              err_pending,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] cap_lo,
    output logic [DATA_W-1:0] cap_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lo <= '0;
            cap_hi <= '0;
        end else if (err_evt && !err_pending) begin
            cap_lo <= addr_lo;
            cap_hi <= addr_hi;
        end
    end

    AST_FIRST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        err_pending |=> ($stable(cap_lo) && $stable(cap_hi))); // R10
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_wmask,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              xfer_evt,
    input  logic              buserr_evt,
    input  logic [DATA_W-1:0] err_addr_lo,
    input  logic [DATA_W-1:0] err_addr_hi,
    input  logic              drv_stat_rd,
    input  logic              drv_busy,
    output logic              irq_o
);
    localparam int unsigned PAD_W = DATA_W - PEND_W;

    acc_t              acc;
    pend_t             hw_set;
    pend_t             pend;
    logic [PEND_W-1:0] sw_set;
    logic [PEND_W-1:0] sw_clr;
    logic              auto_clr;
    logic [DATA_W-1:0] cap_lo;
    logic [DATA_W-1:0] cap_hi;
    logic [DATA_W-1:0] rd_mux;

    pirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .wr   (reg_wr),
        .rd   (reg_rd),
        .acc  (acc)
    );

    always_comb begin
        hw_set.xfer   = xfer_evt;
        hw_set.buserr = buserr_evt;
        sw_set   = (acc.wr && acc.sel == ACC_SET) ? reg_wmask : '0;
        sw_clr   = (acc.wr && acc.sel == ACC_CLR) ? reg_wmask : '0;
        auto_clr = drv_stat_rd && !drv_busy;
    end

    pirq_sticky u_sticky (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (hw_set),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr),
        .auto_clr (auto_clr),
        .pend_q   (pend),
        .irq_q    (irq_o)
    );

    pirq_errcap #(.DATA_W(DATA_W)) u_errcap (
        .clk         (clk),
        .rst         (rst),
        .err_evt     (buserr_evt),
        .err_pending (pend.buserr),
        .addr_lo     (err_addr_lo),
        .addr_hi     (err_addr_hi),
        .cap_lo      (cap_lo),
        .cap_hi      (cap_hi)
    );

    always_comb begin
        unique case (acc.sel)
            ACC_ERR_LO: rd_mux = cap_lo;
            ACC_ERR_HI: rd_mux = cap_hi;
            ACC_STAT:   rd_mux = {{PAD_W{1'b0}}, PEND_W'(pend)};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else     reg_rdata <= acc.rd ? rd_mux : '0;
    end

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> (reg_rdata == '0)); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (drv_stat_rd && drv_busy && !xfer_evt && !buserr_evt && !reg_wr) |=> $stable(pend)); // R8
    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && acc.sel == ACC_STAT && !xfer_evt && !buserr_evt && !drv_stat_rd) |=> $stable(pend)); // R11
endmodule

// File: tb/pirq_regs_tb.sv
module pirq_regs_tb_top;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] reg_addr;
    logic          reg_wr, reg_rd;
    logic [1:0]    reg_wmask;
    logic [DW-1:0] reg_rdata;
    logic          xfer_evt, buserr_evt;
    logic [DW-1:0] err_addr_lo, err_addr_hi;
    logic          drv_stat_rd, drv_busy;
    logic          irq_o;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    localparam logic [AW-1:0] OFF_LO   = 8'h00;
    localparam logic [AW-1:0] OFF_HI   = 8'h04;
    localparam logic [AW-1:0] OFF_UNM  = 8'h08;
    localparam logic [AW-1:0] OFF_STAT = 8'h0C;
    localparam logic [AW-1:0] OFF_SET  = 8'h14;
    localparam logic [AW-1:0] OFF_CLR  = 8'h1C;

    always #4 clk = ~clk;

    pirq_regs #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wmask(reg_wmask), .reg_rdata(reg_rdata), .xfer_evt(xfer_evt),
        .buserr_evt(buserr_evt), .err_addr_lo(err_addr_lo), .err_addr_hi(err_addr_hi),
        .drv_stat_rd(drv_stat_rd), .drv_busy(drv_busy), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wmask = '0;
        xfer_evt = 0; buserr_evt = 0; drv_stat_rd = 0; drv_busy = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [1:0] m);
        reg_addr = a; reg_wmask = m; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0; reg_wmask = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a; reg_rd = 1;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 0;
    endtask

    task automatic pulse_err(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
        err_addr_lo = lo; err_addr_hi = hi; buserr_evt = 1;
        @(negedge clk);
        buserr_evt = 0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        check("R1 irq", DW'(irq_o), 0);
        check("R1 rdata", reg_rdata, 0);
        rd(OFF_STAT, d); check("R1 status", d, 0);
        rd(OFF_LO, d);   check("R1 errlo", d, 0);
        rd(OFF_HI, d);   check("R1 errhi", d, 0);
    endtask

    task automatic t_hw_events();
        logic [DW-1:0] d;
        xfer_evt = 1; @(negedge clk); xfer_evt = 0;
        check("R9 irq same edge", DW'(irq_o), 1);
        repeat (3) @(negedge clk);
        rd(OFF_STAT, d); check("R2 xfer sticky", d, 32'h1);
        wr(OFF_CLR, 2'b11);
        check("R4 clear both irq", DW'(irq_o), 0);
        pulse_err(32'h1111_0000, 32'h0000_00AA);
        rd(OFF_STAT, d); check("R2 buserr", d, 32'h2);
        check("R9 irq from buserr", DW'(irq_o), 1);
        wr(OFF_CLR, 2'b11);
    endtask

    task automatic t_sw_set_clear();
        logic [DW-1:0] d;
        wr(OFF_SET, 2'b01); rd(OFF_STAT, d); check("R3 set bit0", d, 32'h1);
        wr(OFF_SET, 2'b10); rd(OFF_STAT, d); check("R3 set bit1", d, 32'h3);
        wr(OFF_CLR, 2'b01); rd(OFF_STAT, d); check("R4 clear bit0 only", d, 32'h2);
        check("R9 irq with bit1", DW'(irq_o), 1);
        wr(OFF_CLR, 2'b10); rd(OFF_STAT, d); check("R4 clear bit1", d, 32'h0);
        check("R9 irq low", DW'(irq_o), 0);
    endtask

    task automatic t_set_wins();
        logic [DW-1:0] d;
        wr(OFF_SET, 2'b10);
        xfer_evt = 1; reg_addr = OFF_CLR; reg_wmask = 2'b11; reg_wr = 1;
        @(negedge clk);
        xfer_evt = 0; reg_wr = 0; reg_wmask = '0;
        rd(OFF_STAT, d); check("R5 hw set beats clear", d, 32'h1);
        buserr_evt = 1; drv_stat_rd = 1; drv_busy = 0;
        @(negedge clk);
        buserr_evt = 0; drv_stat_rd = 0;
        rd(OFF_STAT, d); check("R5 hw set beats auto clear", d, 32'h2);
        wr(OFF_CLR, 2'b11);
    endtask

    task automatic t_drive_read();
        logic [DW-1:0] d;
        wr(OFF_SET, 2'b11);
        drv_stat_rd = 1; drv_busy = 1; @(negedge clk); drv_stat_rd = 0; drv_busy = 0;
        rd(OFF_STAT, d); check("R8 busy keeps flags", d, 32'h3);
        check("R8 busy irq", DW'(irq_o), 1);
        drv_stat_rd = 1; drv_busy = 0; @(negedge clk); drv_stat_rd = 0;
        check("R7 irq dropped", DW'(irq_o), 0);
        rd(OFF_STAT, d); check("R7 flags cleared", d, 32'h0);
    endtask

    task automatic t_err_capture();
        logic [DW-1:0] d;
        pulse_err(32'hDEAD_BEEF, 32'h0000_0012);
        rd(OFF_LO, d); check("R10 lo captured", d, 32'hDEAD_BEEF);
        rd(OFF_HI, d); check("R10 hi captured", d, 32'h0000_0012);
        pulse_err(32'h0BAD_0BAD, 32'h0000_0034);
        rd(OFF_LO, d); check("R10 first kept lo", d, 32'hDEAD_BEEF);
        rd(OFF_HI, d); check("R10 first kept hi", d, 32'h0000_0012);
        wr(OFF_CLR, 2'b10);
        pulse_err(32'h0BAD_0BAD, 32'h0000_0034);
        rd(OFF_LO, d); check("R10 new lo after clear", d, 32'h0BAD_0BAD);
        wr(OFF_CLR, 2'b11);
    endtask

    task automatic t_ignored_and_rdata();
        logic [DW-1:0] d;
        wr(OFF_STAT, 2'b11); rd(OFF_STAT, d); check("R11 status write ignored", d, 32'h0);
        wr(OFF_LO, 2'b11);   rd(OFF_LO, d);   check("R11 errlo write ignored", d, 32'h0BAD_0BAD);
        wr(OFF_HI, 2'b11);   rd(OFF_HI, d);   check("R11 errhi write ignored", d, 32'h0000_0034);
        wr(OFF_SET, 2'b01);
        rd(OFF_STAT, d); check("R6 status read", d, 32'h1);
        @(negedge clk); check("R6 rdata quiet", reg_rdata, 32'h0);
        rd(OFF_UNM, d); check("R6 unmapped zero", d, 32'h0);
        wr(OFF_CLR, 2'b11);
    endtask

    initial begin
        idle_inputs();
        err_addr_lo = '0; err_addr_hi = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_hw_events();
        t_sw_set_clear();
        t_set_wins();
        t_drive_read();
        t_err_capture();
        t_ignored_and_rdata();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule